// File: doc/BRIEF.md
# Dual-Timer Output Compare Modulator

This block drives a single output pin from two timer compare outputs. One channel is a fast-PWM counter. It runs from zero up to a programmable top value and supplies the modulating waveform. The other is a clear-on-match counter whose compare output toggles on every match and supplies the carrier.

When modulation is switched on, a small state machine combines the two registered compare outputs with a logical AND or a logical OR. The port data bit picks which function is used. When modulation is off, the pin carries the PWM output alone. A direction bit decides on its own whether the pin is driven, whatever the modulation settings are.

The state machine has four states. ST_DARK means not driven, with the pin forced low. ST_PASS means PWM only. ST_AND and ST_OR are the two combining modes. On every clock edge it moves to the state decoded from the direction, enable and select inputs:
- direction low goes to ST_DARK from any state.
- enable low goes to ST_PASS.
- select high goes to ST_OR.
- otherwise it goes to ST_AND.

Any state can reach any other state in a single edge.

Top module: `dual_timer_modulator`

## Requirements
- R1: While reset is asserted, and at its release, pin_o and pin_oe are 0, and both counters and both compare outputs are 0. Reset is asynchronous and active low.
- R2: The PWM counter steps 0,1,...,pwm_top and wraps to 0. Its compare output after an edge equals 1 exactly when the counter value before that edge was below pwm_cmp. With dir_en=1 and mod_en=0, pin_o after an edge equals that compare output as it was before the edge.
- R3: With pwm_cmp=0 the PWM output is constantly 0. With pwm_cmp greater than pwm_top it is constantly 1.
- R4: The carrier counter steps 0..car_cmp and then returns to 0. The carrier output inverts on each edge at which the counter equals car_cmp, which gives a period of 2*(car_cmp+1) clocks.
- R5: With dir_en=1, mod_en=1 and port_sel=0, pin_o after an edge is the AND of the PWM and carrier outputs before it.
- R6: With dir_en=1, mod_en=1 and port_sel=1, pin_o after an edge is the OR of the PWM and carrier outputs before it.
- R7: pin_oe after an edge equals dir_en before it, independent of mod_en and port_sel. While pin_oe is 0, pin_o is 0.
- R8: Consider car_cmp=0, an even PWM period and AND mode. Then pwm_cmp values 2m+1 and 2m+2 give identical pin sequences, while 2m and 2m+1 do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Modulator enable |
| port_sel | input | 1 | Combining function: 0 AND, 1 OR |
| dir_en | input | 1 | Pin output enable request |
| pwm_top | input | CNT_W | PWM counter top value |
| pwm_cmp | input | CNT_W | PWM compare value |
| car_cmp | input | CNT_W | Carrier counter compare value |
| pin_o | output | 1 | Pin value |
| pin_oe | output | 1 | Pin output enable |

## Verification
Each compare output is due one rising edge after the counter value that causes it. The pin value and its enable are due one further edge after the compare outputs and the direction bit.

The bench keeps a step model that advances once per rising edge and compares at the following falling edge. It therefore checks each result in the first cycle it is due, with no allowance for early or late values.

Settings change only while reset is held. Each configuration in the sweep is therefore checked from a known alignment of both counters.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
    localparam int DTM_CNT_W = 8;

    typedef enum logic [1:0] {
        ST_DARK = 2'd0,
        ST_PASS = 2'd1,
        ST_AND  = 2'd2,
        ST_OR   = 2'd3
    } dtm_state_e;
endpackage

// File: rtl/dtm_pwm_chan.sv
module dtm_pwm_chan #(
    parameter int CNT_W = dtm_pkg::DTM_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] top_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             oc_o
);
    localparam logic [CNT_W-1:0] BOTTOM = '0;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= BOTTOM;
        end else if (cnt_q >= top_i) begin
            cnt_q <= BOTTOM;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // compare match clears, bottom sets; a match at bottom wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oc_o <= 1'b0;
        end else if (cnt_q == cmp_i) begin
            oc_o <= 1'b0;
        end else if (cnt_q == BOTTOM) begin
            oc_o <= 1'b1;
        end
    end
endmodule

// File: rtl/dtm_ctc_carrier.sv
module dtm_ctc_carrier #(
    parameter int CNT_W = dtm_pkg::DTM_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             oc_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    assign hit = (cnt_q >= cmp_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            oc_o  <= 1'b0;
        end else begin
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
            if (hit) begin
                oc_o <= ~oc_o;
            end
        end
    end
endmodule

// File: rtl/dtm_pin_fsm.sv
module dtm_pin_fsm
    import dtm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic sel_i,
    input  logic dir_i,
    input  logic mod_i,
    input  logic car_i,
    output logic pin_o,
    output logic oe_o
);
    dtm_state_e state_q;
    dtm_state_e state_nx;

    always_comb begin
        if (!dir_i) begin
            state_nx = ST_DARK;
        end else if (!en_i) begin
            state_nx = ST_PASS;
        end else if (sel_i) begin
            state_nx = ST_OR;
        end else begin
            state_nx = ST_AND;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DARK;
        end else begin
            state_q <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_o <= 1'b0;
        end else begin
            unique case (state_nx)
                ST_DARK: pin_o <= 1'b0;
                ST_PASS: pin_o <= mod_i;
                ST_AND:  pin_o <= mod_i & car_i;
                ST_OR:   pin_o <= mod_i | car_i;
                default: pin_o <= 1'b0;
            endcase
        end
    end

    assign oe_o = (state_q != ST_DARK);
endmodule

// File: rtl/dual_timer_modulator.sv
module dual_timer_modulator #(
    parameter int CNT_W = dtm_pkg::DTM_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_en,
    input  logic             port_sel,
    input  logic             dir_en,
    input  logic [CNT_W-1:0] pwm_top,
    input  logic [CNT_W-1:0] pwm_cmp,
    input  logic [CNT_W-1:0] car_cmp,
    output logic             pin_o,
    output logic             pin_oe
);
    logic pwm_oc;
    logic car_oc;

    dtm_pwm_chan #(.CNT_W(CNT_W)) u_pwm (
        .clk   (clk),
        .rst_n (rst_n),
        .top_i (pwm_top),
        .cmp_i (pwm_cmp),
        .oc_o  (pwm_oc)
    );

    dtm_ctc_carrier #(.CNT_W(CNT_W)) u_car (
        .clk   (clk),
        .rst_n (rst_n),
        .cmp_i (car_cmp),
        .oc_o  (car_oc)
    );

    dtm_pin_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (mod_en),
        .sel_i (port_sel),
        .dir_i (dir_en),
        .mod_i (pwm_oc),
        .car_i (car_oc),
        .pin_o (pin_o),
        .oe_o  (pin_oe)
    );
endmodule

// File: rtl/dtm_checker.sv
module dtm_checker #(
    parameter int CNT_W = dtm_pkg::DTM_CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mod_en,
    input logic             port_sel,
    input logic             dir_en,
    input logic [CNT_W-1:0] pwm_cmp,
    input logic             pwm_oc,
    input logic             car_oc,
    input logic             pin_o,
    input logic             pin_oe
);
    AST_OE_ON: assert property (@(posedge clk) disable iff (!rst_n) dir_en |=> pin_oe); // R7
    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n) !dir_en |=> !pin_oe); // R7
    AST_DARK_LOW: assert property (@(posedge clk) disable iff (!rst_n) !pin_oe |-> !pin_o); // R7
    AST_PASS_PWM: assert property (@(posedge clk) disable iff (!rst_n) (dir_en && !mod_en) |=> (pin_o == $past(pwm_oc))); // R2
    AST_AND_MIX: assert property (@(posedge clk) disable iff (!rst_n) (dir_en && mod_en && !port_sel) |=> (pin_o == ($past(pwm_oc) & $past(car_oc)))); // R5
    AST_OR_MIX: assert property (@(posedge clk) disable iff (!rst_n) (dir_en && mod_en && port_sel) |=> (pin_o == ($past(pwm_oc) | $past(car_oc)))); // R6
    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n) (pwm_cmp == '0 && $past(pwm_cmp) == '0) |-> !pwm_oc); // R3
endmodule

bind dual_timer_modulator dtm_checker #(.CNT_W(CNT_W)) u_dtm_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mod_en   (mod_en),
    .port_sel (port_sel),
    .dir_en   (dir_en),
    .pwm_cmp  (pwm_cmp),
    .pwm_oc   (pwm_oc),
    .car_oc   (car_oc),
    .pin_o    (pin_o),
    .pin_oe   (pin_oe)
);

// File: tb/dual_timer_modulator_bench.sv
module dual_timer_modulator_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mod_en = 1'b0;
    logic         port_sel = 1'b0;
    logic         dir_en = 1'b0;
    logic [W-1:0] pwm_top = '0;
    logic [W-1:0] pwm_cmp = '0;
    logic [W-1:0] car_cmp = '0;
    logic         pin_o;
    logic         pin_oe;

    int n_chk = 0;
    int n_fail = 0;

    int m_cnt, m_ccnt;
    logic m_pwm, m_car, m_pin, m_oe;

    always #2.5 clk = ~clk;

    dual_timer_modulator #(.CNT_W(W)) u_dual_timer_modulator (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .port_sel(port_sel),
        .dir_en(dir_en), .pwm_top(pwm_top), .pwm_cmp(pwm_cmp),
        .car_cmp(car_cmp), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b (top=%0d cmp=%0d car=%0d en=%0b sel=%0b dir=%0b)",
                     tag, what, act, exp, pwm_top, pwm_cmp, car_cmp, mod_en, port_sel, dir_en);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_ccnt = 0; m_pwm = 0; m_car = 0; m_pin = 0; m_oe = 0;
    endtask

    // one rising edge of the requirement model, using values before the edge
    task automatic model_step();
        int n_cnt, n_ccnt;
        logic n_pwm, n_car, n_pin;
        n_cnt  = (m_cnt >= int'(pwm_top)) ? 0 : m_cnt + 1;
        n_pwm  = (m_cnt < int'(pwm_cmp));
        n_ccnt = (m_ccnt >= int'(car_cmp)) ? 0 : m_ccnt + 1;
        n_car  = (m_ccnt == int'(car_cmp)) ? ~m_car : m_car;
        if (!dir_en)       n_pin = 1'b0;
        else if (!mod_en)  n_pin = m_pwm;
        else if (port_sel) n_pin = m_pwm | m_car;
        else               n_pin = m_pwm & m_car;
        m_oe = dir_en;
        m_cnt = n_cnt; m_pwm = n_pwm; m_ccnt = n_ccnt; m_car = n_car; m_pin = n_pin;
    endtask

    task automatic start_cfg(input int top, input int cmp, input int cc,
                             input logic en, input logic sel, input logic dir);
        @(negedge clk);
        rst_n = 1'b0;
        pwm_top = W'(top); pwm_cmp = W'(cmp); car_cmp = W'(cc);
        mod_en = en; port_sel = sel; dir_en = dir;
        model_reset();
        @(negedge clk);
        chk("R1", pin_o, 1'b0, "pin in reset");
        chk("R1", pin_oe, 1'b0, "oe in reset");
        rst_n = 1'b1;
    endtask

    task automatic run_cfg(input int top, input int cmp, input int cc, input int mode, input int ncyc);
        logic en, sel, dir;
        string tag;
        en  = (mode == 1 || mode == 2 || mode == 3);
        sel = (mode == 2 || mode == 4);
        dir = (mode <= 2);
        if (!dir)                           tag = "R7";
        else if (!en)                       tag = (cmp == 0 || cmp > top) ? "R3" : "R2";
        else if (sel && cmp == 0)           tag = "R4";
        else                                tag = sel ? "R6" : "R5";
        start_cfg(top, cmp, cc, en, sel, dir);
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            model_step();
            chk(tag, pin_o, m_pin, "pin value");
            chk("R7", pin_oe, m_oe, "output enable");
        end
    endtask

    task automatic capture(input int cmp, output logic [23:0] seq);
        start_cfg(7, cmp, 0, 1'b1, 1'b0, 1'b1);
        repeat (8) @(negedge clk);
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            seq[k] = pin_o;
        end
    endtask

    task automatic run_all();
        logic [23:0] s2, s3, s4;
        for (int top = 1; top <= 5; top++)
            for (int cmp = 0; cmp <= top + 1; cmp++)
                for (int cc = 0; cc <= 2; cc++)
                    for (int mode = 0; mode <= 4; mode++)
                        run_cfg(top, cmp, cc, mode, 30);
        // R8: resolution lost to a two-cycle carrier
        capture(2, s2);
        capture(3, s3);
        capture(4, s4);
        n_chk++;
        if (s3 !== s4) begin
            n_fail++;
            $display("FAIL R8 cmp3 vs cmp4: actual %h expected %h", s4, s3);
        end
        n_chk++;
        if (s2 === s3) begin
            n_fail++;
            $display("FAIL R8 cmp2 vs cmp3: actual %h expected a different sequence from %h", s3, s2);
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                #(5.0 * 150000);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule